// File: doc/BRIEF.md
# Input Capture Unit with Overflow-Extended Measurement

This block watches a small set of timer input pins and measures either the period of a signal or the width of one of its pulses. A free-running counter of `CNT_W` bits is cleared and restarted by every capture on the selected pin. The counter value at each capture is stored in a per-channel capture register. A measurement engine adds the number of counter wraps seen while a measurement is open, so results reach `OVF_W + CNT_W` bits.

Software-side setup is reduced to a few inputs: a channel select, a period/pulse mode bit, a polarity bit, a single/continuous bit and per-channel filter enables. `arm_i` starts the unit and `disarm_i` stops it. Arming derives the channel's 4-bit edge code from the mode and polarity and stores it in a packed control image. One byte of that image serves each channel pair. The block raises a one-cycle strobe with each result and one-cycle interrupt pulses for captures and counter wraps, each gated by its own enable bit.

Top module: `icap_ext`

## Requirements
- R1: After reset, `busy_o`, `result_o`, `result_vld_o`, `io_ctrl_o`, `cap_o`, `cnt_o` and `irq_o` are all zero.
- R2: An arm while idle latches channel, mode, polarity and repeat setting, and writes the channel's edge code into bits 4c+3..4c of `io_ctrl_o`. An even channel takes the low nibble of its pair byte and an odd channel the high nibble. The codes are 0x9 (falling edge) for period mode with normal polarity, 0x8 (rising edge) for period mode inverted, and 0xA (both edges) for pulse mode. All other nibbles keep their values.
- R3: An arm while busy is refused: `io_ctrl_o` and the running measurement are left unchanged.
- R4: Each pin passes a two-flop synchronizer. With its filter enabled, a level change is accepted only after `FILT_LEN` consecutive equal samples, so shorter glitches produce no capture. With the filter off, every change is seen.
- R5: A capture on the selected channel copies the counter into that channel's capture register and restarts the count, so a capture N cycles later reads N mod 2^CNT_W.
- R6: In period mode, the first capture opens a measurement and the next one closes it. The result is the number of cycles between the two edges, equal to wraps × 2^CNT_W plus the captured value.
- R7: In pulse mode, a capture that leaves the pin at its active level opens a measurement: high for normal polarity, low for inverted. A capture at the opposite level closes an open measurement with the pulse width. A closing edge with no open measurement gives no result.
- R8: The wrap count is cleared when a measurement opens and counts only while one is open, so wraps before the opening edge do not enter the result.
- R9: In single mode, the first result disables the unit: `busy_o` falls, the channel's capture register reads 0, and the counter is cleared and stopped.
- R10: In continuous mode, the unit stays busy after a result and the next opening capture starts a fresh measurement.
- R11: `disarm_i` while busy has the same effect as R9.
- R12: `irq_o[c]` pulses for one cycle, the cycle after a capture on channel c, when `irq_en_i[c]` is set. `irq_o[NUM_CH]` pulses the cycle after a counter wrap when `irq_en_i[NUM_CH]` is set. A cleared enable bit masks its pulse.
- R13: `result_vld_o` is high for exactly one cycle, the cycle after a closing capture, and `result_o` holds until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_CH | Raw capture pins |
| filt_en_i | input | NUM_CH | Per-channel glitch filter enable |
| ch_sel_i | input | $clog2(NUM_CH) | Channel to measure, latched at arm |
| pulse_mode_i | input | 1 | 1: pulse width, 0: period |
| invert_i | input | 1 | Inverted polarity |
| continuous_i | input | 1 | 1: keep measuring, 0: stop after one result |
| arm_i | input | 1 | Start request |
| disarm_i | input | 1 | Stop request |
| irq_en_i | input | NUM_CH+1 | Capture enables per channel, top bit wrap enable |
| io_ctrl_o | output | 4*NUM_CH | Packed edge codes, one nibble per channel |
| cap_o | output | NUM_CH*CNT_W | Capture registers |
| cnt_o | output | CNT_W | Counter value |
| busy_o | output | 1 | Unit armed |
| result_o | output | OVF_W+CNT_W | Last measurement |
| result_vld_o | output | 1 | Result strobe |
| irq_o | output | NUM_CH+1 | Capture pulses per channel, top bit wrap pulse |

## Verification
The bench builds the block with `CNT_W = 8` and `OVF_W = 8`, so the counter wraps every 256 cycles. Periods and pulse widths of a few hundred cycles therefore exercise the extension logic, including the exact 256-cycle boundary where the captured value is zero. `FILT_LEN = 3` makes two-cycle glitches rejectable with the filter on and measurable with it off. `NUM_CH = 4` fills two pair bytes, so nibble preservation is seen for both even and odd channels.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam logic [3:0] EDGE_RISE = 4'h8;
  localparam logic [3:0] EDGE_FALL = 4'h9;
  localparam logic [3:0] EDGE_BOTH = 4'hA;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_MEAS
  } meas_st_e;
endpackage

// File: rtl/icap_in_cond.sv
module icap_in_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic filt_en_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int RUN_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic             lvl_q, prev_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= lvl_q;
      if (!filt_en_i || sync_q[1] == lvl_q) begin
        run_q <= '0;
        if (!filt_en_i) lvl_q <= sync_q[1];
      end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
        lvl_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (restart_i) cnt_q <= CNT_W'(1);  // capture cycle counts as the first tick
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = run_i & ~clr_i & ~restart_i & (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/icap_engine.sv
module icap_engine
  import icap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   arm_i,
  input  logic                   pulse_i,
  input  logic                   inv_i,
  input  logic                   cont_i,
  input  logic                   cap_i,
  input  logic                   lvl_i,
  input  logic                   wrap_i,
  input  logic                   disarm_i,
  input  logic [CNT_W-1:0]       cnt_i,
  output logic                   busy_o,
  output logic                   cont_o,
  output logic                   stop_o,
  output logic [OVF_W+CNT_W-1:0] result_o,
  output logic                   vld_o
);
  meas_st_e               st_q;
  logic                   pulse_q, inv_q, cont_q, vld_q;
  logic [OVF_W-1:0]       ovf_q;
  logic [OVF_W+CNT_W-1:0] res_q;
  logic                   act_lvl, opens, closes, fin;

  assign act_lvl = (lvl_i == ~inv_q);
  assign opens   = pulse_q ? act_lvl : (st_q == ST_ARMED);
  assign closes  = (st_q == ST_MEAS) & (pulse_q ? ~act_lvl : 1'b1);
  assign fin     = cap_i & closes;
  assign busy_o  = (st_q != ST_IDLE);
  assign stop_o  = busy_o & (disarm_i | (fin & ~cont_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pulse_q <= 1'b0;
      inv_q   <= 1'b0;
      cont_q  <= 1'b0;
      ovf_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= fin;
      if (fin) res_q <= {ovf_q, cnt_i};
      if (arm_i && st_q == ST_IDLE) begin
        st_q    <= ST_ARMED;
        pulse_q <= pulse_i;
        inv_q   <= inv_i;
        cont_q  <= cont_i;
      end else if (stop_o) begin
        st_q <= ST_IDLE;
      end else if (cap_i && opens) begin
        st_q  <= ST_MEAS;
        ovf_q <= '0;
      end else if (fin) begin
        st_q <= ST_ARMED;
      end else if (wrap_i && st_q == ST_MEAS) begin
        ovf_q <= ovf_q + 1'b1;
      end
    end
  end

  assign cont_o   = cont_q;
  assign result_o = res_q;
  assign vld_o    = vld_q;
endmodule

// File: rtl/icap_ext.sv
module icap_ext
  import icap_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CNT_W    = 16,
  parameter int OVF_W    = 16,
  parameter int FILT_LEN = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          pin_i,
  input  logic [NUM_CH-1:0]          filt_en_i,
  input  logic [$clog2(NUM_CH)-1:0]  ch_sel_i,
  input  logic                       pulse_mode_i,
  input  logic                       invert_i,
  input  logic                       continuous_i,
  input  logic                       arm_i,
  input  logic                       disarm_i,
  input  logic [NUM_CH:0]            irq_en_i,
  output logic [4*NUM_CH-1:0]        io_ctrl_o,
  output logic [NUM_CH*CNT_W-1:0]    cap_o,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       busy_o,
  output logic [OVF_W+CNT_W-1:0]     result_o,
  output logic                       result_vld_o,
  output logic [NUM_CH:0]            irq_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] lvl, rise, fall;
  logic [CH_W-1:0]   ch_q;
  logic [4*NUM_CH-1:0] io_q;
  logic [3:0]        code_sel, code_new;
  logic              arm_take, hit, cap_ev, stop_req, cont_q, wrap;
  logic [NUM_CH:0]   irq_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    icap_in_cond #(.FILT_LEN(FILT_LEN)) u_cond (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[c]),
      .filt_en_i(filt_en_i[c]),
      .lvl_o    (lvl[c]),
      .rise_o   (rise[c]),
      .fall_o   (fall[c])
    );

    logic [CNT_W-1:0] cap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               cap_q <= '0;
      else if (stop_req && ch_q == CH_W'(c))     cap_q <= '0;
      else if (cap_ev && ch_q == CH_W'(c))       cap_q <= cnt_o;
    end
    assign cap_o[c*CNT_W +: CNT_W] = cap_q;
  end

  assign arm_take = arm_i & ~busy_o;
  assign code_new = pulse_mode_i ? EDGE_BOTH : (invert_i ? EDGE_RISE : EDGE_FALL);
  assign code_sel = io_q[ch_q*4 +: 4];
  assign hit = ((code_sel == EDGE_RISE) & rise[ch_q]) |
               ((code_sel == EDGE_FALL) & fall[ch_q]) |
               ((code_sel == EDGE_BOTH) & (rise[ch_q] | fall[ch_q]));
  assign cap_ev = busy_o & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q <= '0;
      io_q <= '0;
    end else if (arm_take) begin
      ch_q <= ch_sel_i;
      io_q[ch_sel_i*4 +: 4] <= code_new;  // partner nibble of the byte is untouched
    end
  end

  icap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy_o),
    .clr_i    (arm_take | stop_req),
    .restart_i(cap_ev),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap)
  );

  icap_engine #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_take),
    .pulse_i (pulse_mode_i),
    .inv_i   (invert_i),
    .cont_i  (continuous_i),
    .cap_i   (cap_ev),
    .lvl_i   (lvl[ch_q]),
    .wrap_i  (wrap),
    .disarm_i(disarm_i),
    .cnt_i   (cnt_o),
    .busy_o  (busy_o),
    .cont_o  (cont_q),
    .stop_o  (stop_req),
    .result_o(result_o),
    .vld_o   (result_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else begin
      for (int c = 0; c < NUM_CH; c++)
        irq_q[c] <= cap_ev & (ch_q == CH_W'(c)) & irq_en_i[c];
      irq_q[NUM_CH] <= wrap & irq_en_i[NUM_CH];
    end
  end

  assign io_ctrl_o = io_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/icap_ext_chk.sv
module icap_ext_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                arm_i,
  input logic                busy_o,
  input logic [4*NUM_CH-1:0] io_ctrl_o,
  input logic [CNT_W-1:0]    cnt_o,
  input logic                result_vld_o,
  input logic [NUM_CH:0]     irq_o,
  input logic [NUM_CH:0]     irq_en_i,
  input logic                cap_ev,
  input logic                stop_req,
  input logic                cont_q
);
  AST_REFUSE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && arm_i |=> $stable(io_ctrl_o)); // R3
  AST_RESTART_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev && !stop_req |=> cnt_o == CNT_W'(1)); // R5
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cnt_o == '0); // R9
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_vld_o && !cont_q |-> !busy_o); // R9
  AST_VLD_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_vld_o |-> $past(busy_o)); // R13
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(irq_en_i)) == '0); // R12
  AST_CAP_IRQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o[NUM_CH-1:0])); // R12
endmodule

bind icap_ext icap_ext_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .busy_o      (busy_o),
  .io_ctrl_o   (io_ctrl_o),
  .cnt_o       (cnt_o),
  .result_vld_o(result_vld_o),
  .irq_o       (irq_o),
  .irq_en_i    (irq_en_i),
  .cap_ev      (cap_ev),
  .stop_req    (stop_req),
  .cont_q      (cont_q)
);

// File: tb/test_icap_ext.sv
module test_icap_ext;
  localparam int NUM_CH = 4, CNT_W = 8, OVF_W = 8, FILT_LEN = 3;
  localparam int RES_W = OVF_W + CNT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_CH-1:0] pin = '0, filt = '0;
  logic [1:0] ch_sel = '0;
  logic pulse_m = 1'b0, inv = 1'b0, cont = 1'b0, arm = 1'b0, disarm = 1'b0;
  logic [NUM_CH:0] irq_en = '0;
  logic [4*NUM_CH-1:0] io_ctrl;
  logic [NUM_CH*CNT_W-1:0] cap;
  logic [CNT_W-1:0] cnt;
  logic busy, vld;
  logic [RES_W-1:0] result;
  logic [NUM_CH:0] irq;

  always #4 clk = ~clk;

  icap_ext #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .OVF_W(OVF_W), .FILT_LEN(FILT_LEN)) i_icap_ext (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .filt_en_i(filt), .ch_sel_i(ch_sel),
    .pulse_mode_i(pulse_m), .invert_i(inv), .continuous_i(cont), .arm_i(arm),
    .disarm_i(disarm), .irq_en_i(irq_en), .io_ctrl_o(io_ctrl), .cap_o(cap), .cnt_o(cnt),
    .busy_o(busy), .result_o(result), .result_vld_o(vld), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0, n_vld = 0;
  int n_irq [NUM_CH+1];
  int last_res = 0;
  bit done = 0;

  initial for (int i = 0; i <= NUM_CH; i++) n_irq[i] = 0;

  always @(negedge clk) begin
    if (vld) begin n_vld++; last_res = int'(result); end
    for (int i = 0; i <= NUM_CH; i++) if (irq[i]) n_irq[i]++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1;
    n_vld = 0;
    for (int i = 0; i <= NUM_CH; i++) n_irq[i] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_arm(input int ch, input bit p, input bit iv, input bit ct);
    @(negedge clk);
    ch_sel = 2'(ch); pulse_m = p; inv = iv; cont = ct; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk); disarm = 1'b1;
    @(negedge clk); disarm = 1'b0;
  endtask

  task automatic wave(input int ch, input int hi, input int lo, input int reps);
    for (int r = 0; r < reps; r++) begin
      @(negedge clk); pin[ch] = 1'b1;
      idle(hi - 1);
      @(negedge clk); pin[ch] = 1'b0;
      idle(lo - 1);
    end
  endtask

  function automatic int cap_of(input int ch);
    return int'(cap[ch*CNT_W +: CNT_W]);
  endfunction

  typedef struct packed {
    logic        pulse;
    logic        inv;
    logic [1:0]  ch;
    logic        filt;
    logic [11:0] hi;
    logic [11:0] lo;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 2'd0, 1'b0, 12'd20,  12'd30},
    '{1'b1, 1'b0, 2'd1, 1'b0, 12'd25,  12'd40},
    '{1'b0, 1'b1, 2'd2, 1'b1, 12'd100, 12'd200},
    '{1'b1, 1'b1, 2'd3, 1'b0, 12'd10,  12'd700},
    '{1'b1, 1'b0, 2'd0, 1'b1, 12'd520, 12'd15},
    '{1'b0, 1'b0, 2'd3, 1'b1, 12'd5,   12'd5},
    '{1'b0, 1'b0, 2'd1, 1'b0, 12'd128, 12'd128},
    '{1'b1, 1'b0, 2'd2, 1'b0, 12'd255, 12'd10}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL R13 watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 vld", int'(vld), 0);
    chk("R1 io_ctrl", int'(io_ctrl), 0);
    chk("R1 cap", int'(cap), 0);
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 / R3 nibble packing and refusal
    do_arm(1, 1'b0, 1'b0, 1'b0);
    chk("R2 odd nibble falling", int'(io_ctrl), 'h0090);
    chk("R2 busy after arm", int'(busy), 1);
    do_arm(2, 1'b1, 1'b0, 1'b0);
    chk("R3 refused arm keeps io_ctrl", int'(io_ctrl), 'h0090);
    chk("R3 still busy", int'(busy), 1);
    do_disarm();
    chk("R11 disarm clears busy", int'(busy), 0);
    do_arm(0, 1'b1, 1'b0, 1'b0);
    chk("R2 even nibble both keeps partner", int'(io_ctrl), 'h009A);
    do_disarm();
    do_arm(2, 1'b0, 1'b1, 1'b0);
    chk("R2 period inverted rising", int'(io_ctrl), 'h089A);
    do_disarm();

    // R6 R7 R9 R13 vector table
    foreach (VECS[k]) begin
      automatic vec_t v = VECS[k];
      automatic int exp = v.pulse ? (v.inv ? int'(v.lo) : int'(v.hi)) : int'(v.hi) + int'(v.lo);
      filt[v.ch] = v.filt;
      idle(8);
      clear_mon();
      do_arm(int'(v.ch), v.pulse, v.inv, 1'b0);
      idle(4);
      wave(int'(v.ch), int'(v.hi), int'(v.lo), 3);
      idle(12);
      chk(v.pulse ? "R7 pulse width" : "R6 period", last_res, exp);
      chk("R13 one strobe", n_vld, 1);
      chk("R13 result held", int'(result), exp);
      chk("R9 single stops", int'(busy), 0);
      chk("R9 cap reg cleared", cap_of(int'(v.ch)), 0);
      chk("R9 counter cleared", int'(cnt), 0);
      filt[v.ch] = 1'b0;
    end

    // R7 closing edge without opening
    @(negedge clk) pin[0] = 1'b1;
    idle(8);
    clear_mon();
    do_arm(0, 1'b1, 1'b0, 1'b0);
    idle(4);
    @(negedge clk) pin[0] = 1'b0;
    idle(20);
    chk("R7 stop without start gives none", n_vld, 0);
    chk("R7 still busy", int'(busy), 1);
    wave(0, 30, 10, 1);
    idle(10);
    chk("R7 pulse after stray stop", last_res, 30);

    // R4 filter rejects short glitch
    filt[1] = 1'b1;
    idle(6);
    clear_mon();
    do_arm(1, 1'b1, 1'b0, 1'b0);
    idle(4);
    wave(1, 2, 20, 1);
    chk("R4 glitch filtered", n_vld, 0);
    wave(1, 12, 20, 1);
    chk("R4 filtered pulse width", last_res, 12);
    filt[1] = 1'b0;
    idle(6);
    clear_mon();
    do_arm(1, 1'b1, 1'b0, 1'b0);
    idle(4);
    wave(1, 2, 20, 1);
    chk("R4 unfiltered glitch measured", last_res, 2);
    chk("R4 unfiltered strobe", n_vld, 1);

    // R10 continuous, R5 capture value, R12 capture irq
    irq_en = 5'b01000;
    idle(4);
    clear_mon();
    do_arm(3, 1'b0, 1'b0, 1'b1);
    idle(4);
    wave(3, 100, 200, 4);
    idle(10);
    chk("R10 two results", n_vld, 2);
    chk("R10 period value", last_res, 300);
    chk("R10 stays busy", int'(busy), 1);
    chk("R5 capture mod 2^W", cap_of(3), 300 % 256);
    chk("R12 capture irq count", n_irq[3], 4);
    chk("R12 other channel silent", n_irq[0], 0);
    do_disarm();
    chk("R11 busy low", int'(busy), 0);
    chk("R11 cap cleared", cap_of(3), 0);
    idle(10);
    chk("R11 counter stopped", int'(cnt), 0);

    // R8 wraps before start ignored, R12 wrap irq
    irq_en = 5'b10000;
    idle(4);
    clear_mon();
    do_arm(0, 1'b0, 1'b0, 1'b0);
    idle(700);
    chk("R12 wrap irq seen", int'(n_irq[4] >= 2), 1);
    wave(0, 50, 50, 2);
    idle(10);
    chk("R8 early wraps excluded", last_res, 100);
    irq_en = '0;
    idle(4);
    clear_mon();
    do_arm(0, 1'b0, 1'b0, 1'b0);
    idle(600);
    chk("R12 wrap irq masked", n_irq[4], 0);
    chk("R12 capture irq masked", n_irq[0], 0);
    do_disarm();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule